// File: doc/BRIEF.md
# Trap Entry State Update Unit

This block computes and registers the architectural control state a processor core holds after it takes a trap. When the trap strobe is high for one cycle, it reads the trap type, a three-bit target-mode select and the current processor state word, hypervisor state word, global register level, current window pointer and free-window count. It registers the rewritten values of all of these on that clock edge. In the same edge it also captures the trap type and a copy of the incoming hypervisor state word.

The target mode can be privileged, hyperprivileged or error/reset. It decides which processor-state bits are forced or copied, how the hypervisor state word changes, and how high the global level may climb. The window pointer moves by an amount chosen from the range the trap type falls in, and it wraps modulo the number of register windows. Between strobes every output register holds its value, so the surrounding pipeline can read the post-trap state at any time.

Top module: `trap_entry_unit`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) loads new_gl with MAX_GL. It loads new_hpstate with only bit 5 (red) and bit 2 (hpriv) set, and sets new_pstate, new_cwp, saved_tt and saved_htstate to zero.
- R2: On a clock edge with rst low and trap_valid low, every output register keeps its previous value.
- R3: On a trap edge (trap_valid high), saved_tt takes trap_type and saved_htstate takes cur_hpstate.
- R4: On a trap edge, new_gl becomes the smaller of cur_gl+1 and a ceiling. The ceiling is MAX_PGL when the effective mode is privileged and MAX_GL otherwise.
- R5: On a trap edge in privileged or hyperprivileged mode, new_pstate equals cur_pstate with these changes: bit 4 (pef) set, bit 3 (am) cleared, bit 1 (ie) cleared, plus the mode-specific changes in R6 and R7. All other bits, bit 8 (tle) among them, pass through unchanged.
- R6: In privileged mode, new_pstate bit 2 (priv) is set and new_pstate bit 9 (cle) takes cur_pstate bit 8 (tle). new_hpstate equals cur_hpstate.
- R7: In hyperprivileged mode, new_pstate bit 9 (cle) is cleared and bit 2 (priv) passes through. new_hpstate equals cur_hpstate with bit 5 (red) cleared, bit 2 (hpriv) set and bit 10 (ibe) cleared.
- R8: In error mode, new_pstate keeps only cur_pstate bit 2 and has bit 4 set, with all other bits zero. new_hpstate equals cur_hpstate with bit 5 set, bit 2 set and bit 10 cleared.
- R9: On a trap edge, new_cwp is computed modulo NWIN from cur_cwp and trap_type. Type 0x24 adds 1. Types 0x80 to 0xBF add cur_cansave+2. Types 0xC0 to 0xFF subtract 1. Any other type leaves it unchanged. cur_cwp and cur_cansave are below NWIN.
- R10: tgt_sel bit 2 selects error mode, bit 1 selects hyperprivileged mode and bit 0 selects privileged mode. Error mode outranks hyperprivileged mode, which outranks privileged mode. With no bit set, the mode is privileged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trap_valid | input | 1 | One-cycle trap strobe |
| trap_type | input | 8 | Trap type code |
| tgt_sel | input | 3 | Target mode select: bit 2 error, bit 1 hyperprivileged, bit 0 privileged |
| cur_pstate | input | PS_W | Current processor state word |
| cur_hpstate | input | HS_W | Current hypervisor state word |
| cur_gl | input | GL_W | Current global register level |
| cur_cwp | input | CWP_W | Current window pointer |
| cur_cansave | input | CWP_W | Free-window count |
| new_pstate | output | PS_W | Registered processor state word |
| new_hpstate | output | HS_W | Registered hypervisor state word |
| new_gl | output | GL_W | Registered global level |
| new_cwp | output | CWP_W | Registered window pointer |
| saved_tt | output | 8 | Captured trap type |
| saved_htstate | output | HS_W | Captured hypervisor state word |

## Verification
Each output is a single register loaded on the trap edge, so a wrong next-state function shows at the ports one cycle after the strobe. A wrong hold path shows on the first idle cycle after it. The bench compares every output on every clock, so a mode misdecode, a wrong ceiling or a bad window wrap is reported within one cycle of the trap that exposes it. The directed cases cover the window pointer wrapping past zero and past NWIN-1. They also cover a global level that already sits above the privileged ceiling, and every combination of the three mode-select bits.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
   typedef enum logic [1:0] {
      TGT_PRIV  = 2'd0,
      TGT_HPRIV = 2'd1,
      TGT_ERR   = 2'd2
   } tgt_mode_e;

   // processor state word bit positions
   localparam int PS_IE   = 1;
   localparam int PS_PRIV = 2;
   localparam int PS_AM   = 3;
   localparam int PS_PEF  = 4;
   localparam int PS_TLE  = 8;
   localparam int PS_CLE  = 9;
   localparam int PS_MIN_W = PS_CLE + 1;

   // hypervisor state word bit positions
   localparam int HS_HPRIV = 2;
   localparam int HS_RED   = 5;
   localparam int HS_IBE   = 10;
   localparam int HS_MIN_W = HS_IBE + 1;

   // trap type that advances the window by one
   localparam logic [7:0] TT_WIN_STEP = 8'h24;
endpackage

// File: rtl/trap_mode_sel.sv
module trap_mode_sel
   import trap_entry_pkg::*;
(
   input  logic [2:0] sel,
   output tgt_mode_e  mode
);
   // priority: error > hyperprivileged > privileged (also the default)
   always_comb begin
      casez (sel)
         3'b1??:  mode = TGT_ERR;
         3'b01?:  mode = TGT_HPRIV;
         default: mode = TGT_PRIV;
      endcase
   end
endmodule

// File: rtl/trap_state_rewrite.sv
module trap_state_rewrite
   import trap_entry_pkg::*;
#(
   parameter int PS_W = 13,
   parameter int HS_W = 12
) (
   input  tgt_mode_e        mode,
   input  logic [PS_W-1:0]  ps_in,
   input  logic [HS_W-1:0]  hs_in,
   output logic [PS_W-1:0]  ps_out,
   output logic [HS_W-1:0]  hs_out
);
   if (PS_W < PS_MIN_W) begin : g_bad_ps
      $error("trap_state_rewrite: PS_W too small");
   end
   if (HS_W < HS_MIN_W) begin : g_bad_hs
      $error("trap_state_rewrite: HS_W too small");
   end

   always_comb begin
      ps_out = ps_in;
      hs_out = hs_in;
      unique case (mode)
         TGT_ERR: begin
            ps_out          = '0;
            ps_out[PS_PRIV] = ps_in[PS_PRIV];
            ps_out[PS_PEF]  = 1'b1;
            hs_out[HS_RED]  = 1'b1;
            hs_out[HS_HPRIV]= 1'b1;
            hs_out[HS_IBE]  = 1'b0;
         end
         TGT_HPRIV: begin
            ps_out[PS_PEF]  = 1'b1;
            ps_out[PS_AM]   = 1'b0;
            ps_out[PS_IE]   = 1'b0;
            ps_out[PS_CLE]  = 1'b0;
            hs_out[HS_RED]  = 1'b0;
            hs_out[HS_HPRIV]= 1'b1;
            hs_out[HS_IBE]  = 1'b0;
         end
         default: begin
            ps_out[PS_PEF]  = 1'b1;
            ps_out[PS_AM]   = 1'b0;
            ps_out[PS_IE]   = 1'b0;
            ps_out[PS_PRIV] = 1'b1;
            ps_out[PS_CLE]  = ps_in[PS_TLE];
         end
      endcase
   end
endmodule

// File: rtl/trap_gl_step.sv
module trap_gl_step
   import trap_entry_pkg::*;
#(
   parameter int GL_W    = 3,
   parameter int MAX_GL  = 6,
   parameter int MAX_PGL = 2
) (
   input  tgt_mode_e        mode,
   input  logic [GL_W-1:0]  gl_in,
   output logic [GL_W-1:0]  gl_out
);
   localparam int EXT_W = GL_W + 1;
   localparam logic [EXT_W-1:0] CEIL_FULL = EXT_W'(MAX_GL);
   localparam logic [EXT_W-1:0] CEIL_PRIV = EXT_W'(MAX_PGL);

   if (MAX_GL >= (1 << GL_W)) begin : g_bad_max
      $error("trap_gl_step: MAX_GL does not fit GL_W");
   end
   if (MAX_PGL > MAX_GL) begin : g_bad_pmax
      $error("trap_gl_step: MAX_PGL exceeds MAX_GL");
   end

   logic [EXT_W-1:0] inc;
   logic [EXT_W-1:0] ceil_v;

   always_comb begin
      inc    = {1'b0, gl_in} + EXT_W'(1);
      ceil_v = (mode == TGT_PRIV) ? CEIL_PRIV : CEIL_FULL;
      gl_out = (inc > ceil_v) ? ceil_v[GL_W-1:0] : inc[GL_W-1:0];
   end
endmodule

// File: rtl/trap_cwp_step.sv
module trap_cwp_step
   import trap_entry_pkg::*;
#(
   parameter int NWIN  = 8,
   parameter int CWP_W = 3
) (
   input  logic [7:0]        tt,
   input  logic [CWP_W-1:0]  cwp_in,
   input  logic [CWP_W-1:0]  cansave,
   output logic [CWP_W-1:0]  cwp_out
);
   localparam int  SUM_W   = CWP_W + 2;
   localparam bit  IS_POW2 = ((NWIN & (NWIN - 1)) == 0);
   localparam logic [SUM_W-1:0] WRAP = SUM_W'(NWIN);
   localparam logic [SUM_W-1:0] DEC  = SUM_W'(NWIN - 1);

   if (NWIN < 2) begin : g_bad_nwin
      $error("trap_cwp_step: NWIN must be at least 2");
   end

   logic [SUM_W-1:0] delta;
   logic [SUM_W-1:0] raw;

   always_comb begin
      if (tt == TT_WIN_STEP)
         delta = SUM_W'(1);
      else if (tt[7:6] == 2'b10)
         delta = {2'b00, cansave} + SUM_W'(2);
      else if (tt[7:6] == 2'b11)
         delta = DEC;
      else
         delta = '0;
      raw = {2'b00, cwp_in} + delta;
   end

   if (IS_POW2) begin : g_wrap_pow2
      assign cwp_out = raw[CWP_W-1:0];
   end else begin : g_wrap_sub
      // raw never exceeds 2*NWIN, so two conditional subtractions suffice
      logic [SUM_W-1:0] r1;
      logic [SUM_W-1:0] r2;
      always_comb begin
         r1 = (raw >= WRAP) ? raw - WRAP : raw;
         r2 = (r1  >= WRAP) ? r1  - WRAP : r1;
      end
      assign cwp_out = r2[CWP_W-1:0];
   end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_entry_pkg::*;
#(
   parameter int PS_W    = 13,
   parameter int HS_W    = 12,
   parameter int GL_W    = 3,
   parameter int MAX_GL  = 6,
   parameter int MAX_PGL = 2,
   parameter int NWIN    = 8,
   localparam int CWP_W  = (NWIN > 2) ? $clog2(NWIN) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              trap_valid,
   input  logic [7:0]        trap_type,
   input  logic [2:0]        tgt_sel,
   input  logic [PS_W-1:0]   cur_pstate,
   input  logic [HS_W-1:0]   cur_hpstate,
   input  logic [GL_W-1:0]   cur_gl,
   input  logic [CWP_W-1:0]  cur_cwp,
   input  logic [CWP_W-1:0]  cur_cansave,
   output logic [PS_W-1:0]   new_pstate,
   output logic [HS_W-1:0]   new_hpstate,
   output logic [GL_W-1:0]   new_gl,
   output logic [CWP_W-1:0]  new_cwp,
   output logic [7:0]        saved_tt,
   output logic [HS_W-1:0]   saved_htstate
);
   localparam logic [HS_W-1:0] HS_RST =
      (HS_W'(1) << HS_RED) | (HS_W'(1) << HS_HPRIV);

   tgt_mode_e          mode;
   logic [PS_W-1:0]    ps_nxt;
   logic [HS_W-1:0]    hs_nxt;
   logic [GL_W-1:0]    gl_nxt;
   logic [CWP_W-1:0]   cwp_nxt;

   trap_mode_sel u_mode (
      .sel  (tgt_sel),
      .mode (mode)
   );

   trap_state_rewrite #(.PS_W(PS_W), .HS_W(HS_W)) u_rewrite (
      .mode   (mode),
      .ps_in  (cur_pstate),
      .hs_in  (cur_hpstate),
      .ps_out (ps_nxt),
      .hs_out (hs_nxt)
   );

   trap_gl_step #(.GL_W(GL_W), .MAX_GL(MAX_GL), .MAX_PGL(MAX_PGL)) u_gl (
      .mode   (mode),
      .gl_in  (cur_gl),
      .gl_out (gl_nxt)
   );

   trap_cwp_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
      .tt      (trap_type),
      .cwp_in  (cur_cwp),
      .cansave (cur_cansave),
      .cwp_out (cwp_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         new_pstate    <= '0;
         new_hpstate   <= HS_RST;
         new_gl        <= GL_W'(MAX_GL);
         new_cwp       <= '0;
         saved_tt      <= '0;
         saved_htstate <= '0;
      end else if (trap_valid) begin
         new_pstate    <= ps_nxt;
         new_hpstate   <= hs_nxt;
         new_gl        <= gl_nxt;
         new_cwp       <= cwp_nxt;
         saved_tt      <= trap_type;
         saved_htstate <= cur_hpstate;
      end
   end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
   import trap_entry_pkg::*;
#(
   parameter int PS_W    = 13,
   parameter int HS_W    = 12,
   parameter int GL_W    = 3,
   parameter int MAX_GL  = 6,
   parameter int MAX_PGL = 2,
   parameter int NWIN    = 8,
   parameter int CWP_W   = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              trap_valid,
   input logic [7:0]        trap_type,
   input logic [2:0]        tgt_sel,
   input logic [PS_W-1:0]   cur_pstate,
   input logic [HS_W-1:0]   cur_hpstate,
   input logic [GL_W-1:0]   cur_gl,
   input logic [CWP_W-1:0]  cur_cwp,
   input logic [CWP_W-1:0]  cur_cansave,
   input logic [PS_W-1:0]   new_pstate,
   input logic [HS_W-1:0]   new_hpstate,
   input logic [GL_W-1:0]   new_gl,
   input logic [CWP_W-1:0]  new_cwp,
   input logic [7:0]        saved_tt,
   input logic [HS_W-1:0]   saved_htstate
);
   localparam logic [PS_W-1:0] ERR_KEEP =
      (PS_W'(1) << PS_PRIV) | (PS_W'(1) << PS_PEF);

   // effective mode seen from the select pins (R10)
   logic is_err, is_hp, is_pr, tt_other;
   assign is_err   = tgt_sel[2];
   assign is_hp    = !tgt_sel[2] && tgt_sel[1];
   assign is_pr    = !tgt_sel[2] && !tgt_sel[1];
   assign tt_other = (trap_type != TT_WIN_STEP) && !trap_type[7];

   assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !trap_valid |=> $stable(new_pstate) && $stable(new_hpstate) && $stable(new_gl)
                      && $stable(new_cwp) && $stable(saved_tt) && $stable(saved_htstate));

   assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
      trap_valid |=> saved_tt == $past(trap_type) && saved_htstate == $past(cur_hpstate));

   assert_gl_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
      trap_valid |=> int'(new_gl) <= MAX_GL);

   assert_gl_priv_ceiling_R4: assert property (@(posedge clk) disable iff (rst)
      trap_valid && is_pr |=> int'(new_gl) <= MAX_PGL);

   assert_pstate_common_R5: assert property (@(posedge clk) disable iff (rst)
      trap_valid |=> new_pstate[PS_PEF] && !new_pstate[PS_AM] && !new_pstate[PS_IE]);

   assert_priv_mode_R6: assert property (@(posedge clk) disable iff (rst)
      trap_valid && is_pr |=> new_pstate[PS_PRIV]
         && new_pstate[PS_CLE] == $past(cur_pstate[PS_TLE])
         && new_hpstate == $past(cur_hpstate));

   assert_hpriv_mode_R7: assert property (@(posedge clk) disable iff (rst)
      trap_valid && is_hp |=> !new_pstate[PS_CLE]
         && new_pstate[PS_PRIV] == $past(cur_pstate[PS_PRIV])
         && !new_hpstate[HS_RED] && new_hpstate[HS_HPRIV] && !new_hpstate[HS_IBE]);

   assert_err_mode_R8: assert property (@(posedge clk) disable iff (rst)
      trap_valid && is_err |=> (new_pstate & ~ERR_KEEP) == '0 && new_pstate[PS_PEF]
         && new_pstate[PS_PRIV] == $past(cur_pstate[PS_PRIV])
         && new_hpstate[HS_RED] && new_hpstate[HS_HPRIV] && !new_hpstate[HS_IBE]);

   assert_cwp_other_R9: assert property (@(posedge clk) disable iff (rst)
      trap_valid && tt_other |=> new_cwp == $past(cur_cwp));

   assert_cwp_range_R9: assert property (@(posedge clk) disable iff (rst)
      trap_valid && int'(cur_cwp) < NWIN && int'(cur_cansave) < NWIN
         |=> int'(new_cwp) < NWIN);
endmodule

bind trap_entry_unit trap_entry_chk #(
   .PS_W(PS_W), .HS_W(HS_W), .GL_W(GL_W), .MAX_GL(MAX_GL),
   .MAX_PGL(MAX_PGL), .NWIN(NWIN), .CWP_W(CWP_W)
) u_chk (.*);

// File: tb/trap_entry_unit_tb.sv
`timescale 1ns/1ps
module trap_entry_unit_tb;
   localparam int PS_W = 13, HS_W = 12, GL_W = 3;
   localparam int MAX_GL = 6, MAX_PGL = 2, NWIN = 8;
   localparam int CWP_W = $clog2(NWIN);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic              rst, trap_valid;
   logic [7:0]        trap_type;
   logic [2:0]        tgt_sel;
   logic [PS_W-1:0]   cur_pstate, new_pstate;
   logic [HS_W-1:0]   cur_hpstate, new_hpstate, saved_htstate;
   logic [GL_W-1:0]   cur_gl, new_gl;
   logic [CWP_W-1:0]  cur_cwp, cur_cansave, new_cwp;
   logic [7:0]        saved_tt;

   trap_entry_unit #(.PS_W(PS_W), .HS_W(HS_W), .GL_W(GL_W), .MAX_GL(MAX_GL),
                     .MAX_PGL(MAX_PGL), .NWIN(NWIN)) u_dut (.*);

   int checks = 0, failures = 0;
   logic [PS_W-1:0] e_ps;
   logic [HS_W-1:0] e_hs, e_hts;
   int              e_gl, e_cwp, e_tt;
   string t_ps, t_hs, t_gl, t_cwp, t_tt;

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference, applied at each rising edge
   task automatic model_step();
      bit err, hp;
      int ceil, g, c;
      if (rst) begin
         e_ps = '0; e_hs = '0; e_hs[5] = 1'b1; e_hs[2] = 1'b1;
         e_gl = MAX_GL; e_cwp = 0; e_tt = 0; e_hts = '0;
         t_ps = "R1"; t_hs = "R1"; t_gl = "R1"; t_cwp = "R1"; t_tt = "R1";
      end else if (!trap_valid) begin
         t_ps = "R2"; t_hs = "R2"; t_gl = "R2"; t_cwp = "R2"; t_tt = "R2";
      end else begin
         err = tgt_sel[2];
         hp  = !err && tgt_sel[1];
         e_tt = trap_type; e_hts = cur_hpstate;
         ceil = (err || hp) ? MAX_GL : MAX_PGL;
         g = int'(cur_gl) + 1;
         e_gl = (g > ceil) ? ceil : g;
         e_hs = cur_hpstate;
         if (err) begin
            e_ps = '0; e_ps[2] = cur_pstate[2]; e_ps[4] = 1'b1;
            e_hs[5] = 1'b1; e_hs[2] = 1'b1; e_hs[10] = 1'b0;
            t_ps = "R8"; t_hs = "R8";
         end else begin
            e_ps = cur_pstate; e_ps[4] = 1'b1; e_ps[3] = 1'b0; e_ps[1] = 1'b0;
            if (hp) begin
               e_ps[9] = 1'b0;
               e_hs[5] = 1'b0; e_hs[2] = 1'b1; e_hs[10] = 1'b0;
               t_ps = "R5,R7"; t_hs = "R7";
            end else begin
               e_ps[2] = 1'b1; e_ps[9] = cur_pstate[8];
               t_ps = "R5,R6"; t_hs = "R6";
            end
         end
         if ($countones(tgt_sel) != 1) begin t_ps = "R10"; t_hs = "R10"; end
         c = int'(cur_cwp);
         if (trap_type == 8'h24) c = c + 1;
         else if (trap_type >= 8'h80 && trap_type <= 8'hBF) c = c + int'(cur_cansave) + 2;
         else if (trap_type >= 8'hC0) c = c + NWIN - 1;
         e_cwp = c % NWIN;
         t_gl = "R4"; t_cwp = "R9"; t_tt = "R3";
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(t_ps,  "new_pstate",    new_pstate,    e_ps);
      chk(t_hs,  "new_hpstate",   new_hpstate,   e_hs);
      chk(t_gl,  "new_gl",        new_gl,        e_gl);
      chk(t_cwp, "new_cwp",       new_cwp,       e_cwp);
      chk(t_tt,  "saved_tt",      saved_tt,      e_tt);
      chk(t_tt,  "saved_htstate", saved_htstate, e_hts);
   endtask

   task automatic trap(logic [7:0] tt, logic [2:0] sel, int gl, int cwp, int cs,
                       logic [PS_W-1:0] ps, logic [HS_W-1:0] hs);
      trap_valid = 1'b1; trap_type = tt; tgt_sel = sel;
      cur_gl = GL_W'(gl); cur_cwp = CWP_W'(cwp); cur_cansave = CWP_W'(cs);
      cur_pstate = ps; cur_hpstate = hs;
      tick();
      trap_valid = 1'b0;
   endtask

   task automatic scramble();
      trap_type = 8'($urandom); tgt_sel = 3'($urandom);
      cur_pstate = PS_W'($urandom); cur_hpstate = HS_W'($urandom);
      cur_gl = GL_W'($urandom); cur_cwp = CWP_W'($urandom_range(NWIN - 1));
      cur_cansave = CWP_W'($urandom_range(NWIN - 1));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1; trap_valid = 1'b0;
      scramble();
      // R1: reset state
      tick(); tick();
      rst = 1'b0;
      // R2: idle cycles with noisy inputs
      for (int i = 0; i < 5; i++) begin scramble(); tick(); end
      // R9: window pointer cases, including wrap in both directions
      trap(8'h24, 3'b001, 0, 7, 0, '0, '0);
      trap(8'h80, 3'b001, 0, 5, 7, '0, '0);
      trap(8'hBF, 3'b010, 0, 0, 3, '0, '0);
      trap(8'hC0, 3'b001, 0, 0, 0, '0, '0);
      trap(8'hFF, 3'b001, 0, 4, 0, '0, '0);
      trap(8'h23, 3'b001, 0, 3, 5, '0, '0);
      trap(8'h25, 3'b001, 0, 3, 5, '0, '0);
      trap(8'h7F, 3'b001, 0, 6, 5, '0, '0);
      // R4: global level ceilings
      trap(8'h10, 3'b001, 1, 0, 0, '0, '0);
      trap(8'h10, 3'b001, 2, 0, 0, '0, '0);
      trap(8'h10, 3'b001, 5, 0, 0, '0, '0);
      trap(8'h10, 3'b010, 6, 0, 0, '0, '0);
      trap(8'h10, 3'b100, 5, 0, 0, '0, '0);
      trap(8'h10, 3'b100, 7, 0, 0, '0, '0);
      // R5..R8: state word rewrites with all-ones and all-zero inputs
      trap(8'h01, 3'b001, 0, 0, 0, '1, '1);
      trap(8'h01, 3'b001, 0, 0, 0, PS_W'(13'h0100), '0);
      trap(8'h01, 3'b010, 0, 0, 0, '1, '1);
      trap(8'h01, 3'b010, 0, 0, 0, '0, '0);
      trap(8'h01, 3'b100, 0, 0, 0, '1, '1);
      trap(8'h01, 3'b100, 0, 0, 0, '0, '0);
      // R10: every select combination
      for (int s = 0; s < 8; s++) trap(8'h30, 3'(s), 3, 2, 1, '1, '1);
      // R2: hold after a trap
      scramble(); tick(); tick();
      // mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         scramble();
         trap_valid = ($urandom_range(3) != 0);
         if ($urandom_range(199) == 0) rst = 1'b1;
         tick();
         rst = 1'b0;
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule